// File: doc/BRIEF.md
# Microcoded Matrix Sequencer

This block is the control unit of a small fixed-point math coprocessor. A host writes a start address into the microprogram counter. The write raises a run flag. While the flag is high, the sequencer reads one 16-bit horizontal microword per instruction cycle from an external instruction ROM. It turns the word's control bits into one-cycle strobes for the register, accumulator and RAM datapath. It also forms a data-RAM address, either directly from the word or from a host-loaded block index combined with the word's low bits.

The instruction cycle is a fixed number of system clocks (`CLK_DIV`), set by a divider that runs only while the sequencer is busy. At the last clock of each cycle the current word is issued and the counter steps by one. If the multiplier reports busy at that point, the issue is skipped until a later cycle finds it idle. A halt bit ends the run one clock after its strobe. An accumulator-to-RAM write strobe is stretched to `WR_LEN` clocks.

Top module: `mseq_top`

## Requirements
- R1: While reset is low and right after it, `run` is 0, `rom_addr` is 0, `blk_idx` is 0, `ram_addr` is 0 and every strobe is 0.
- R2: A `host_start` pulse without `host_abort` loads `host_start_addr` into `rom_addr` and sets `run` on the same clock edge. The first strobes of that program appear exactly `CLK_DIV` clocks later.
- R3: Microword bits have fixed meanings: 15 loads A, 14 loads B, 13 loads C and starts a multiply, 12 clears the accumulator, 11 increments the block index, 10 halts, 9 writes the accumulator to RAM, 8 loads the accumulator, 7 selects direct mode. All set bits of one word strobe in the same clock.
- R4: After a word with bit 10 set, `run` falls one clock after that word's strobes, and `rom_addr` rests one past the halting word's address.
- R5: `rom_addr` increments by one with every issued word, so consecutive words execute in address order.
- R6: In direct mode (bit 7 = 1), `ram_addr` equals bits 6..0 of the word, and all higher address bits are zero whatever the block index holds.
- R7: In indirect mode (bit 7 = 0), `ram_addr` is {`blk_idx`, word bits 1..0}, using the block index value from before any increment in the same word.
- R8: A `host_blk_load` pulse writes `host_blk_val` into `blk_idx` at the next edge. Bit 11 adds one, modulo 2^(`RAM_AW`-2).
- R9: If `mult_busy` is high at the end of an instruction cycle, no strobe is issued and `rom_addr` holds. If busy is held indefinitely, `run` stays high.
- R10: The RAM-write strobe lasts `WR_LEN` clocks. A halt in the same word still drops `run` one clock after the strobe starts.
- R11: `host_abort` clears `run` at the next edge, and no later strobe or counter step follows. If `host_start` and `host_abort` arrive together, abort wins.
- R12: Without stalls, consecutive words are issued exactly `CLK_DIV` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_start | input | 1 | Host write of a start address |
| host_start_addr | input | UADDR_W | Start address for the microprogram |
| host_abort | input | 1 | Host abort of a running microprogram |
| host_blk_load | input | 1 | Host load of the block index |
| host_blk_val | input | RAM_AW-2 | Value written into the block index |
| mult_busy | input | 1 | Multiplier busy; withholds the next issue |
| rom_data | input | 16 | Microword at `rom_addr` (combinational ROM) |
| rom_addr | output | UADDR_W | Microprogram counter |
| run | output | 1 | Sequencer busy flag |
| str_lda | output | 1 | Load register A strobe |
| str_ldb | output | 1 | Load register B strobe |
| str_ldc | output | 1 | Load register C / start multiply strobe |
| str_clr_acc | output | 1 | Clear accumulator strobe |
| str_ld_acc | output | 1 | Load accumulator strobe |
| str_wr_acc | output | 1 | Accumulator-to-RAM write strobe (long) |
| ram_addr | output | RAM_AW | Data-RAM address for the current strobes |
| blk_idx | output | RAM_AW-2 | Block index counter |

## Verification
Most internal faults show up within one instruction cycle. A wrong counter or a missed issue appears on `rom_addr` at the clock of the strobe. A wrong decode shows as a wrong strobe set or a wrong `ram_addr` in that same clock. A broken halt latch leaves `run` high one clock too long, or indefinitely. A stall that fails to hold appears one full instruction cycle early, as strobes that arrive before the expected double gap. A faulty block index shows only on the next indirect word, so the bench chains indirect words after increments and after wrap-around.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int UWORD_W = 16;
  localparam int OFS_W   = 7;

  // Field order matches the microword bit positions (15 down to 0).
  typedef struct packed {
    logic             lda;      // 15
    logic             ldb;      // 14
    logic             ldc;      // 13: also starts multiply
    logic             clr_acc;  // 12
    logic             blk_inc;  // 11
    logic             halt;     // 10
    logic             wr_acc;   // 9
    logic             ld_acc;   // 8
    logic             direct;   // 7
    logic [OFS_W-1:0] ofs;      // 6..0
  } uword_t;

endpackage

// File: rtl/mseq_tick.sv
module mseq_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (restart || !run)      cnt <= '0;
    else if (cnt == LAST)          cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mseq_pc.sv
module mseq_pc #(
  parameter int UADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_ok,
  input  logic [UADDR_W-1:0] start_addr,
  input  logic               abort,
  input  logic               issue,
  input  logic               halt_bit,
  output logic [UADDR_W-1:0] pc,
  output logic               run,
  output logic               halt_pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)        pc <= '0;
    else if (start_ok) pc <= start_addr;
    else if (issue)    pc <= pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 halt_pend <= 1'b0;
    else if (abort || start_ok) halt_pend <= 1'b0;
    else                        halt_pend <= issue && halt_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         run <= 1'b0;
    else if (abort)     run <= 1'b0;
    else if (start_ok)  run <= 1'b1;
    else if (halt_pend) run <= 1'b0;
  end
endmodule

// File: rtl/mseq_blk.sv
module mseq_blk #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] load_val,
  input  logic             inc,
  output logic [BLK_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= load_val;
    else if (inc)  idx <= idx + 1'b1;
  end
endmodule

// File: rtl/mseq_strobe.sv
module mseq_strobe
  import mseq_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter int WR_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  uword_t            uop,
  input  logic [RAM_AW-3:0] blk,
  output logic              str_lda,
  output logic              str_ldb,
  output logic              str_ldc,
  output logic              str_clr_acc,
  output logic              str_ld_acc,
  output logic              str_wr_acc,
  output logic [RAM_AW-1:0] ram_addr
);
  localparam int BLK_W = RAM_AW - 2;
  localparam int WCW   = $clog2(WR_LEN + 1);

  // Address selector: direct uses the 7-bit offset, indirect pairs the
  // block index with the offset's two low bits.
  function automatic logic [RAM_AW-1:0] sel_addr(input uword_t u,
                                                 input logic [BLK_W-1:0] b);
    logic [RAM_AW-1:0] a;
    a = '0;
    if (u.direct) a[OFS_W-1:0] = u.ofs;
    else          a = {b, u.ofs[1:0]};
    return a;
  endfunction

  logic [WCW-1:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      str_lda     <= 1'b0;
      str_ldb     <= 1'b0;
      str_ldc     <= 1'b0;
      str_clr_acc <= 1'b0;
      str_ld_acc  <= 1'b0;
    end else begin
      str_lda     <= issue && uop.lda;
      str_ldb     <= issue && uop.ldb;
      str_ldc     <= issue && uop.ldc;
      str_clr_acc <= issue && uop.clr_acc;
      str_ld_acc  <= issue && uop.ld_acc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  wr_cnt <= '0;
    else if (issue && uop.wr_acc) wr_cnt <= WCW'(WR_LEN);
    else if (wr_cnt != '0)       wr_cnt <= wr_cnt - 1'b1;
  end

  assign str_wr_acc = (wr_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     ram_addr <= '0;
    else if (issue) ram_addr <= sel_addr(uop, blk);
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int UADDR_W = 9,
  parameter int RAM_AW  = 10,
  parameter int CLK_DIV = 8,
  parameter int WR_LEN  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_start,
  input  logic [UADDR_W-1:0] host_start_addr,
  input  logic               host_abort,
  input  logic               host_blk_load,
  input  logic [RAM_AW-3:0]  host_blk_val,
  input  logic               mult_busy,
  input  logic [15:0]        rom_data,
  output logic [UADDR_W-1:0] rom_addr,
  output logic               run,
  output logic               str_lda,
  output logic               str_ldb,
  output logic               str_ldc,
  output logic               str_clr_acc,
  output logic               str_ld_acc,
  output logic               str_wr_acc,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic [RAM_AW-3:0]  blk_idx
);
  localparam int BLK_W = RAM_AW - 2;

  // Named internal events (observed by the bound checker).
  uword_t uop;
  logic   tick;
  logic   start_ok;
  logic   issue;
  logic   halt_pend;

  assign uop      = uword_t'(rom_data);
  assign start_ok = host_start && !host_abort;
  assign issue    = tick && !mult_busy && !host_abort && !host_start;

  mseq_tick #(.DIV(CLK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (start_ok),
    .tick    (tick)
  );

  mseq_pc #(.UADDR_W(UADDR_W)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .start_addr (host_start_addr),
    .abort      (host_abort),
    .issue      (issue),
    .halt_bit   (uop.halt),
    .pc         (rom_addr),
    .run        (run),
    .halt_pend  (halt_pend)
  );

  mseq_blk #(.BLK_W(BLK_W)) u_blk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (host_blk_load),
    .load_val (host_blk_val),
    .inc      (issue && uop.blk_inc),
    .idx      (blk_idx)
  );

  mseq_strobe #(.RAM_AW(RAM_AW), .WR_LEN(WR_LEN)) u_str (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .uop         (uop),
    .blk         (blk_idx),
    .str_lda     (str_lda),
    .str_ldb     (str_ldb),
    .str_ldc     (str_ldc),
    .str_clr_acc (str_clr_acc),
    .str_ld_acc  (str_ld_acc),
    .str_wr_acc  (str_wr_acc),
    .ram_addr    (ram_addr)
  );
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int UADDR_W = 9,
  parameter int RAM_AW  = 10,
  parameter int WR_LEN  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_start,
  input logic [UADDR_W-1:0] host_start_addr,
  input logic               host_abort,
  input logic               mult_busy,
  input logic [15:0]        rom_data,
  input logic [UADDR_W-1:0] rom_addr,
  input logic               run,
  input logic               str_lda,
  input logic               str_ldb,
  input logic               str_ldc,
  input logic               str_clr_acc,
  input logic               str_ld_acc,
  input logic               str_wr_acc,
  input logic [RAM_AW-1:0]  ram_addr,
  input logic               tick,
  input logic               issue,
  input logic               halt_pend
);
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (host_start && !host_abort) |=> (run && rom_addr == $past(host_start_addr)));

  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    host_abort |=> !run);

  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (rom_addr == UADDR_W'($past(rom_addr) + 1'b1)));

  a_r4_halt_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && rom_data[10]) |=> halt_pend);

  a_r4_halt_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_pend && !host_start) |=> !run);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && mult_busy && !host_start) |=> $stable(rom_addr));

  a_r3_pulses_from_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (str_lda || str_ldb || str_ldc || str_clr_acc || str_ld_acc) |-> $past(issue));

  a_r6_direct_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && rom_data[7]) |=> (ram_addr[RAM_AW-1:7] == '0));

  generate
    if (WR_LEN > 1) begin : g_long
      a_r10_write_stretched: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(str_wr_acc) |=> str_wr_acc);
    end
  endgenerate
endmodule

bind mseq_top mseq_chk #(.UADDR_W(UADDR_W), .RAM_AW(RAM_AW), .WR_LEN(WR_LEN)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .host_start      (host_start),
  .host_start_addr (host_start_addr),
  .host_abort      (host_abort),
  .mult_busy       (mult_busy),
  .rom_data        (rom_data),
  .rom_addr        (rom_addr),
  .run             (run),
  .str_lda         (str_lda),
  .str_ldb         (str_ldb),
  .str_ldc         (str_ldc),
  .str_clr_acc     (str_clr_acc),
  .str_ld_acc      (str_ld_acc),
  .str_wr_acc      (str_wr_acc),
  .ram_addr        (ram_addr),
  .tick            (tick),
  .issue           (issue),
  .halt_pend       (halt_pend)
);

// File: tb/mseq_top_test.sv
module mseq_top_test;
  localparam int UADDR_W = 9;
  localparam int RAM_AW  = 10;
  localparam int BLK_W   = RAM_AW - 2;
  localparam int CLK_DIV = 8;
  localparam int WR_LEN  = 3;
  localparam int MUL_CYC = 12;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               host_start = 1'b0;
  logic [UADDR_W-1:0] host_start_addr = '0;
  logic               host_abort = 1'b0;
  logic               host_blk_load = 1'b0;
  logic [BLK_W-1:0]   host_blk_val = '0;
  logic               mult_busy;
  logic [15:0]        rom_data;
  logic [UADDR_W-1:0] rom_addr;
  logic               run;
  logic               str_lda, str_ldb, str_ldc, str_clr_acc, str_ld_acc, str_wr_acc;
  logic [RAM_AW-1:0]  ram_addr;
  logic [BLK_W-1:0]   blk_idx;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  mseq_top #(.UADDR_W(UADDR_W), .RAM_AW(RAM_AW), .CLK_DIV(CLK_DIV), .WR_LEN(WR_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_start_addr(host_start_addr),
    .host_abort(host_abort), .host_blk_load(host_blk_load), .host_blk_val(host_blk_val),
    .mult_busy(mult_busy), .rom_data(rom_data), .rom_addr(rom_addr), .run(run),
    .str_lda(str_lda), .str_ldb(str_ldb), .str_ldc(str_ldc), .str_clr_acc(str_clr_acc),
    .str_ld_acc(str_ld_acc), .str_wr_acc(str_wr_acc), .ram_addr(ram_addr), .blk_idx(blk_idx)
  );

  // Instruction ROM stub.
  logic [15:0] rom [0:(1<<UADDR_W)-1];
  assign rom_data = rom[rom_addr];

  // Multiplier stub: busy for MUL_CYC clocks after a C load.
  int  busy_cnt;
  logic force_busy = 1'b0;
  always_ff @(posedge clk) begin
    if (!rst_n)               busy_cnt <= 0;
    else if (str_ldc)         busy_cnt <= MUL_CYC;
    else if (busy_cnt != 0)   busy_cnt <= busy_cnt - 1;
  end
  assign mult_busy = force_busy || (busy_cnt != 0);

  // Strobe vector: lda=32 ldb=16 ldc=8 clr=4 ldacc=2 wr=1
  function automatic int svec();
    return {26'd0, str_lda, str_ldb, str_ldc, str_clr_acc, str_ld_acc, str_wr_acc};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Event log filled by run_prog.
  int ev_n, fall_d, wr_cyc;
  int ev_gap [8];
  int ev_str [8];
  int ev_ram [8];
  int ev_blk [8];

  task automatic run_prog(input logic [UADDR_W-1:0] a);
    logic [UADDR_W-1:0] prev;
    int last;
    @(negedge clk);
    host_start_addr = a;
    host_start = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
    check(run == 1'b1, "R2", "run after start", run, 1);
    check(rom_addr == a, "R2", "counter loaded", rom_addr, a);
    ev_n = 0; fall_d = -1; wr_cyc = 0; last = 0; prev = rom_addr;
    for (int t = 1; t <= 400; t++) begin
      @(negedge clk);
      if (str_wr_acc) wr_cyc++;
      if (rom_addr != prev) begin
        if (ev_n < 8) begin
          ev_gap[ev_n] = t - last;
          ev_str[ev_n] = svec();
          ev_ram[ev_n] = ram_addr;
          ev_blk[ev_n] = blk_idx;
        end
        ev_n++;
        last = t;
        prev = rom_addr;
      end
      if (!run) begin
        fall_d = t - last;
        break;
      end
    end
    repeat (WR_LEN + 2) begin
      @(negedge clk);
      if (str_wr_acc) wr_cyc++;
    end
  endtask

  task automatic load_blk(input logic [BLK_W-1:0] v);
    @(negedge clk);
    host_blk_val = v;
    host_blk_load = 1'b1;
    @(negedge clk);
    host_blk_load = 1'b0;
    check(blk_idx == v, "R8", "block index load", blk_idx, v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(run == 1'b0 && rom_addr == '0, "R1", "run/counter in reset", {run, rom_addr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(run == 1'b0, "R1", "run after reset", run, 0);
    check(rom_addr == '0, "R1", "counter after reset", rom_addr, 0);
    check(blk_idx == '0 && ram_addr == '0, "R1", "index/address after reset",
          {blk_idx, ram_addr}, 0);
    check(svec() == 0, "R1", "strobes after reset", svec(), 0);
  endtask

  task automatic t_single_halt();
    load_blk(8'h2A);
    run_prog(9'h15C);
    check(ev_n == 1, "R4", "word count", ev_n, 1);
    check(ev_gap[0] == CLK_DIV, "R2", "first strobe delay", ev_gap[0], CLK_DIV);
    check(ev_str[0] == 32, "R3", "load A only", ev_str[0], 32);
    check(ev_ram[0] == 'h00F, "R6", "direct address, upper zero", ev_ram[0], 'h00F);
    check(fall_d == 1, "R4", "run drop after halt strobe", fall_d, 1);
    check(rom_addr == 9'h15D, "R4", "counter one past halt", rom_addr, 'h15D);
  endtask

  task automatic t_acc_copy();
    run_prog(9'h170);
    check(ev_n == 2, "R5", "word count", ev_n, 2);
    check(ev_gap[0] == CLK_DIV && ev_gap[1] == CLK_DIV, "R12", "issue spacing",
          ev_gap[1], CLK_DIV);
    check(ev_str[0] == 2 && ev_ram[0] == 0, "R5", "first word load acc @0",
          {ev_str[0], ev_ram[0]}, 2 << 10);
    check(ev_str[1] == 1 && ev_ram[1] == 1, "R5", "second word write @1",
          {ev_str[1], ev_ram[1]}, (1 << 10) | 1);
    check(wr_cyc == WR_LEN, "R10", "write strobe length", wr_cyc, WR_LEN);
    check(fall_d == 1, "R10", "halt with write ends run early", fall_d, 1);
  endtask

  task automatic t_multiply();
    run_prog(9'h174);
    check(ev_n == 4, "R5", "word count", ev_n, 4);
    check(ev_str[0] == 36 && ev_ram[0] == 'h0C, "R3", "load A + clear together",
          ev_str[0], 36);
    check(ev_str[1] == 16 && ev_ram[1] == 'h0D, "R5", "load B @0D", ev_str[1], 16);
    check(ev_str[2] == 8 && ev_ram[2] == 'h0E, "R5", "load C @0E", ev_str[2], 8);
    check(ev_gap[3] == 2 * CLK_DIV, "R9", "stall after multiply", ev_gap[3], 2 * CLK_DIV);
    check(ev_str[3] == 1 && ev_ram[3] == 0, "R10", "store after multiply", ev_str[3], 1);
    check(rom_addr == 9'h178, "R4", "final counter", rom_addr, 'h178);
  endtask

  task automatic t_indirect();
    load_blk(8'h35);
    run_prog(9'h010);
    check(ev_n == 3, "R7", "word count", ev_n, 3);
    check(ev_ram[0] == 'h0D6 && ev_str[0] == 32, "R7", "indirect address 0",
          ev_ram[0], 'h0D6);
    check(ev_ram[1] == 'h0D7, "R7", "address uses pre-increment index", ev_ram[1], 'h0D7);
    check(ev_blk[1] == 'h36, "R8", "index incremented", ev_blk[1], 'h36);
    check(ev_ram[2] == 'h0D9 && ev_str[2] == 16, "R7", "indirect with new index",
          ev_ram[2], 'h0D9);
    load_blk(8'hFF);
    run_prog(9'h011);
    check(ev_ram[0] == 'h3FF, "R7", "top block address", ev_ram[0], 'h3FF);
    check(ev_blk[0] == 0, "R8", "index wraps", ev_blk[0], 0);
    check(ev_ram[1] == 'h001, "R7", "address after wrap", ev_ram[1], 'h001);
  endtask

  task automatic t_all_bits();
    load_blk(8'h10);
    run_prog(9'h020);
    check(ev_str[0] == 63, "R3", "all strobes in one clock", ev_str[0], 63);
    check(ev_ram[0] == 'h045, "R6", "direct address", ev_ram[0], 'h045);
    check(ev_blk[0] == 'h11, "R8", "increment with others", ev_blk[0], 'h11);
    check(ev_n == 2 && ev_gap[1] == 2 * CLK_DIV, "R9", "stall then halt",
          ev_gap[1], 2 * CLK_DIV);
    check(ev_ram[1] == 'h044, "R7", "indirect after increment", ev_ram[1], 'h044);
  endtask

  task automatic t_stall_abort();
    int seen;
    force_busy = 1'b1;
    @(negedge clk);
    host_start_addr = 9'h030;
    host_start = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
    seen = 0;
    repeat (10 * CLK_DIV) begin
      @(negedge clk);
      if (svec() != 0) seen++;
    end
    check(run == 1'b1, "R9", "run held during stall", run, 1);
    check(rom_addr == 9'h030 && seen == 0, "R9", "no issue while busy", rom_addr, 'h030);
    @(negedge clk);
    host_abort = 1'b1;
    @(negedge clk);
    host_abort = 1'b0;
    check(run == 1'b0, "R11", "abort clears run", run, 0);
    force_busy = 1'b0;
    seen = 0;
    repeat (3 * CLK_DIV) begin
      @(negedge clk);
      if (svec() != 0 || run) seen++;
    end
    check(rom_addr == 9'h030 && seen == 0, "R11", "nothing after abort", seen, 0);
    @(negedge clk);
    host_start_addr = 9'h100;
    host_start = 1'b1;
    host_abort = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
    host_abort = 1'b0;
    check(run == 1'b0 && rom_addr == 9'h030, "R11", "abort beats start",
          {run, rom_addr}, 'h030);
  endtask

  initial begin
    for (int i = 0; i < (1 << UADDR_W); i++) rom[i] = 16'h0400;
    rom['h15C] = 16'h848F;
    rom['h170] = 16'h0180; rom['h171] = 16'h0681;
    rom['h174] = 16'h908C; rom['h175] = 16'h408D; rom['h176] = 16'h208E;
    rom['h177] = 16'h0680;
    rom['h010] = 16'h8002; rom['h011] = 16'h0803; rom['h012] = 16'h4401;
    rom['h020] = 16'hFBC5; rom['h021] = 16'h0400;
    rom['h030] = 16'h2000; rom['h031] = 16'h0400;
    t_reset();
    t_single_halt();
    t_acc_copy();
    t_multiply();
    t_indirect();
    t_all_bits();
    t_stall_abort();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule